// File: doc/BRIEF.md
# I2C Serial EEPROM Read Target

This block is an I2C target that serves reads from a read-only byte array the way a serial EEPROM with a two-byte word address does. It oversamples the SCL and SDA lines on a fast system clock, at least eight times the SCL rate. It detects START, repeated START and STOP conditions. It drives SDA only through an open-drain output enable.

A controller loads the internal address pointer with a header that looks like a write. The header carries the device address with the R/W bit low and two word-address bytes. The controller then reads with a repeated START. It may also skip the header and read from wherever the pointer was left. The pointer survives between transactions. It advances by one for every byte handed to the controller and wraps at the top of the array. A read continues byte after byte while the controller acknowledges. It ends when the controller does not acknowledge and then sends a STOP.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: The target answers a device address byte whose upper four bits are 1010 and whose next three bits equal `strap_i[2:0]` (MSB first). Bit 0 is the R/W flag, with 1 meaning read. For a matching byte, the target pulls SDA low during the ninth SCL clock. Each word-address byte it receives is acknowledged the same way.
- R2: A device address that does not match gets no acknowledge. The target then keeps SDA released until the next START.
- R3: A header of START, address with R/W=0 and two word-address bytes loads the pointer. The pointer takes the low `MEM_AW` bits of the 15-bit word address, made of the first byte's bits 6..0 followed by the whole second byte. Bit 7 of the first byte is ignored. A repeated START with R/W=1 then returns the byte at that address.
- R4: A read that follows a completed read of address n, with no header in between, returns the byte at n+1.
- R5: When the controller pulls SDA low in the ninth clock after a data byte, the target sends the byte at the next address.
- R6: When the controller leaves SDA high in the ninth clock after a data byte, the target stops driving. SDA stays released until a STOP, and the target stays released during every controller acknowledge clock.
- R7: The pointer wraps from 2^MEM_AW-1 to 0.
- R8: Data bytes are sent MSB first. The byte stored at address a is the low eight bits of a*29+7.
- R9: The target changes its SDA output only while SCL is low.
- R10: A START or STOP in the middle of a byte abandons that byte. The pointer keeps the value it had after the last completed byte, and a START restarts address reception.
- R11: After reset, SDA is released.
- R12: A header ended by a STOP instead of a repeated START still sets the pointer for a later current-address read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_i | input | 3 | Device address strap pins |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
On every cycle, the embedded properties check four behaviours. SDA is only asserted while SCL is low. The target is released during the controller's acknowledge clock. A START or STOP resets reception and releases the line. The pointer stays still during idle, address and first word-address phases. Only the bench's scenarios can show the rest. That covers the data values returned, the continuity of the pointer across separate transactions, wrap-around, mismatch silence and the effect of an aborted header.

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd #(
  parameter int         MEM_AW     = 8,
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_WA1, ST_WA2, ST_RD} st_t;

  st_t               state;
  logic [2:0]        scl_q, sda_q;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, tx;
  logic [6:0]        hi;
  logic              rw;
  logic [MEM_AW-1:0] ptr;

  wire scl_s     = scl_q[1];
  wire sda_s     = sda_q[1];
  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  wire stop_det  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];

  wire [7:0]        rx_byte   = {shreg[6:0], sda_s};
  wire [14:0]       word_addr = {hi, rx_byte};
  wire [MEM_AW-1:0] ptr_nx    = ptr + 1'b1;

  function automatic logic [7:0] rom_byte(input logic [MEM_AW-1:0] a);
    int v;
    v = int'(a) * 29 + 7;
    return v[7:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      tx       <= '0;
      hi       <= '0;
      rw       <= 1'b0;
      ptr      <= '0;
      sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state    <= ST_DEV;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else if (scl_rise && state != ST_IDLE) begin
      if (bitcnt != 4'd8) begin
        bitcnt <= bitcnt + 4'd1;
        shreg  <= rx_byte;
        if (bitcnt == 4'd7) begin
          case (state)
            ST_DEV: begin
              rw <= rx_byte[0];
              if (rx_byte[7:1] != {DEV_PREFIX, strap_i}) state <= ST_IDLE;
            end
            ST_WA1:  hi  <= rx_byte[6:0];
            ST_WA2:  ptr <= word_addr[MEM_AW-1:0];
            default: ;
          endcase
        end
      end else begin
        bitcnt <= '0;
        case (state)
          ST_DEV: begin
            if (rw) begin
              tx    <= rom_byte(ptr);
              state <= ST_RD;
            end else begin
              state <= ST_WA1;
            end
          end
          ST_WA1: state <= ST_WA2;
          ST_WA2: state <= ST_IDLE;
          ST_RD: begin
            ptr <= ptr_nx;
            if (!sda_s) tx    <= rom_byte(ptr_nx);
            else        state <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end else if (scl_fall) begin
      case (state)
        ST_RD:                 sda_oe_o <= (bitcnt != 4'd8) && !tx[3'd7 - bitcnt[2:0]];
        ST_DEV, ST_WA1, ST_WA2: sda_oe_o <= (bitcnt == 4'd8);
        default:               sda_oe_o <= 1'b0;
      endcase
    end
  end

  AST_OE_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !$past(scl_s)); // R9
  AST_RELEASE_CTRL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && bitcnt == 4'd8 && !scl_s && !scl_q[2]) |-> !sda_oe_o); // R6
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEV && bitcnt == 4'd0 && !sda_oe_o)); // R10
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe_o && state == ST_IDLE)); // R10
  AST_PTR_HELD_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_DEV || state == ST_WA1) |=> $stable(ptr)); // R10
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8); // R8
endmodule

// File: tb/i2c_eeprom_rd_tb.sv
module i2c_eeprom_rd_tb;
  localparam int  AW = 8;
  localparam time Q  = 80ns;

  logic       clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       oe;
  wire        bus = msda & ~oe;
  int         n_chk = 0, n_bad = 0;

  always #5ns clk = ~clk;

  i2c_eeprom_rd #(.MEM_AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus),
    .strap_i(strap), .sda_oe_o(oe)
  );

  function automatic logic [7:0] exp_b(input int a);
    int v;
    v = (a % (1 << AW)) * 29 + 7;
    return v[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    msda = 1'b1; #Q; scl = 1'b1; #Q; msda = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    msda = 1'b0; #Q; scl = 1'b1; #Q; msda = 1'b1; #Q;
  endtask

  task automatic send_bit(input logic b);
    msda = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic read_bit(output logic v);
    msda = 1'b1; #Q; scl = 1'b1; #Q; v = bus; #Q; scl = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    read_bit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic more);
    for (int i = 7; i >= 0; i--) read_bit(d[i]);
    send_bit(!more);
  endtask

  task automatic dev_addr(input logic [2:0] s, input logic r, input string req);
    logic a;
    send_byte({4'b1010, s, r}, a);
    check(req, {7'd0, a}, 8'd0);
  endtask

  task automatic read_run(input int first, input int cnt, input string req);
    logic [7:0] d;
    logic       v;
    for (int i = 0; i < cnt; i++) begin
      recv_byte(d, i < cnt - 1);
      check(req, d, exp_b(first + i));
    end
    read_bit(v);
    check("R6 released after NACK", {7'd0, v}, 8'd1);
    i2c_stop();
  endtask

  task automatic header(input logic [15:0] wa);
    logic a;
    i2c_start();
    dev_addr(strap, 1'b0, "R1 ack write address");
    send_byte(wa[15:8], a); check("R1 ack word byte 1", {7'd0, a}, 8'd0);
    send_byte(wa[7:0], a);  check("R1 ack word byte 2", {7'd0, a}, 8'd0);
  endtask

  task automatic t_random(input logic [15:0] wa, input int cnt);
    header(wa);
    i2c_start();
    dev_addr(strap, 1'b1, "R1 ack read address");
    read_run(int'(wa[14:0]), cnt, "R3 random read data");
  endtask

  task automatic t_current(input int idx, input int cnt, input string req);
    i2c_start();
    dev_addr(strap, 1'b1, "R4 ack current read");
    read_run(idx, cnt, req);
  endtask

  task automatic t_mismatch();
    logic       a;
    logic [7:0] d;
    i2c_start();
    send_byte({4'b1010, 3'b100, 1'b1}, a);
    check("R2 no ack on mismatch", {7'd0, a}, 8'd1);
    recv_byte(d, 1'b0);
    check("R2 silent after mismatch", d, 8'hFF);
    i2c_stop();
  endtask

  task automatic t_abort(input int idx);
    logic a;
    i2c_start();
    dev_addr(strap, 1'b0, "R10 ack before abort");
    send_byte(8'h00, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    i2c_start();
    dev_addr(strap, 1'b1, "R10 ack after restart");
    read_run(idx, 1, "R10 pointer kept after abort");
  endtask

  task automatic t_hdr_stop(input logic [15:0] wa);
    header(wa);
    i2c_stop();
    t_current(int'(wa[14:0]), 2, "R12 header then STOP");
  endtask

  initial begin
    #(2ms);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3ns;
    #50ns;
    check("R11 released in reset", {7'd0, oe}, 8'd0);
    rst_n = 1'b1;
    #Q;
    check("R11 released after reset", {7'd0, oe}, 8'd0);
    t_random(16'h1234, 1);
    t_current(16'h35, 1, "R4 current read n+1");
    t_current(16'h36, 4, "R5 sequential bytes, R8 MSB first");
    t_random(16'h80FF, 1);
    t_current(0, 2, "R7 wrap to zero");
    t_mismatch();
    t_abort(2);
    t_hdr_stop(16'h0020);
    t_random(16'h7F5A, 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule